// File: doc/BRIEF.md
# Multiprocessor-capable asynchronous serial receiver

This block takes an idle-high NRZ serial line and turns each character on it into a byte held for a CPU. A falling edge starts a frame. The low level is confirmed at mid-bit using a 16x oversampling enable, `os_tick`, that is generated outside the block. The data bits then arrive least significant bit first. Next comes either an optional parity bit or an address/data marker bit. The frame ends with a high stop bit. Bit timing comes only from `os_tick`, so the baud generator stays outside the block.

There are two frame formats. In normal mode the data field is 7 or 8 bits wide and may carry even or odd parity. In multiprocessor mode the data field is always 8 bits wide. It is followed by one address/data marker bit, and parity is never checked. At the end of a frame the framing, parity and overrun flags are written first. One cycle later the data-full flag rises, and it can raise an interrupt. A single read strobe acknowledges the byte.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame starts only when `rx_line` is low at the mid-point of the start bit, eight `os_tick` pulses after the falling edge is seen. A low pulse that has ended by then is dropped and produces no frame.
- R2: In normal mode with `len_full`=1, eight data bits are received least significant bit first and appear unchanged on `rx_data`.
- R3: In normal mode with `len_full`=0, seven data bits are received and `rx_data[7]` reads 0.
- R4: In normal mode with `parity_en`=1, one parity bit follows the data. `parity_odd`=0 selects even parity and 1 selects odd parity. `parity_err` is 1 when the total count of ones in the data bits and the parity bit does not match the selected parity.
- R5: `frame_err` is 1 for a frame whose stop bit samples low.
- R6: With `mp_mode`=1, eight data bits are received whatever `len_full` is. The bit after the data is presented on `rx_addr_bit`, and `parity_err` stays 0 whatever `parity_en` is. In normal mode `rx_addr_bit` reads 0.
- R7: At the end of a frame, the three error flags take their new values one clock before `rx_full` rises.
- R8: Reset leaves `rx_full`, all error flags and `rx_irq` at 0. A one-cycle `rd_strobe` pulse clears `rx_full` and all error flags on the next clock.
- R9: When a frame completes while `rx_full` is still 1, `overrun_err` is set and `rx_data` keeps the unread byte.
- R10: `rx_irq` is 1 exactly while `rx_full` and `rx_int_en` are both 1.
- R11: While `rx_enable` is 0, no frame is received. Dropping `rx_enable` in the middle of a frame discards that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit time |
| rx_line | input | 1 | Serial input, idle high |
| rx_enable | input | 1 | Receiver enable |
| mp_mode | input | 1 | 1 selects multiprocessor format |
| len_full | input | 1 | Normal mode data length: 1 for 8 bits, 0 for 7 bits |
| parity_en | input | 1 | Normal mode parity enable |
| parity_odd | input | 1 | 1 for odd parity, 0 for even parity |
| rx_int_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Data register read, one cycle |
| rx_data | output | DATA_W | Received byte |
| rx_addr_bit | output | 1 | Received address/data marker |
| rx_full | output | 1 | Unread byte present |
| frame_err | output | 1 | Stop bit sampled low |
| parity_err | output | 1 | Parity mismatch |
| overrun_err | output | 1 | Frame completed while a byte was unread |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Normal mode is driven with all-zero, all-one, alternating and mixed bytes. This separates bit order and stuck data lines from correct LSB-first assembly, and 7-bit frames show whether the top bit leaks. Parity frames are sent with a correct even bit, a correct odd bit and a deliberately wrong bit, so that the parity sense itself is tested and not just the presence of a parity bit. Multiprocessor frames are sent with the marker at 1 and at 0 while `len_full`=0 and `parity_en`=1, to show that both settings are ignored. A low stop bit, a short low glitch, an unread byte followed by a second frame, and enable drops before and during a frame cover the paths that must not deliver a byte or must flag one.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic addr_bit;
    logic frame_err;
    logic parity_err;
  } frame_flags_t;

endpackage

// File: rtl/mpu_rx_sync.sv
module mpu_rx_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d;
    end else begin : g_chain
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mpu_rx_framer.sv
module mpu_rx_framer
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_bit,
  input  logic              rx_enable,
  input  logic              mp_mode,
  input  logic              len_full,
  input  logic              parity_en,
  input  logic              parity_odd,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output frame_flags_t      frame_flags
);

  localparam int OS_W  = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [OS_W-1:0]  OS_MID     = OS_W'(OVERSAMPLE / 2 - 1);
  localparam logic [OS_W-1:0]  OS_LAST    = OS_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_FULL  = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0] LAST_SHORT = BIT_W'(DATA_W - 2);

  rx_state_e          state_q, state_d;
  logic [OS_W-1:0]    os_q, os_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [BIT_W-1:0]   last_q, last_d;
  logic [DATA_W-1:0]  shift_q, shift_d;
  logic               extra_q, extra_d;
  logic               mp_q, mp_d;
  logic               has_extra_q, has_extra_d;
  logic               odd_q, odd_d;
  logic               sample_pt;
  logic               parity_expect;

  assign sample_pt = tick && (os_q == OS_LAST);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    os_d        = os_q;
    bit_d       = bit_q;
    last_d      = last_q;
    shift_d     = shift_q;
    extra_d     = extra_q;
    mp_d        = mp_q;
    has_extra_d = has_extra_q;
    odd_d       = odd_q;
    frame_done  = 1'b0;

    if (!rx_enable) begin
      state_d = ST_IDLE;
      os_d    = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (tick && !rx_bit) begin
            state_d = ST_START;
            os_d    = '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (os_q == OS_MID) begin
              os_d = '0;
              if (!rx_bit) begin
                state_d     = ST_DATA;
                bit_d       = '0;
                shift_d     = '0;
                extra_d     = 1'b0;
                mp_d        = mp_mode;
                odd_d       = parity_odd;
                has_extra_d = mp_mode || parity_en;
                last_d      = (mp_mode || len_full) ? LAST_FULL : LAST_SHORT;
              end else begin
                state_d = ST_IDLE;
              end
            end else begin
              os_d = os_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sample_pt) begin
            os_d           = '0;
            shift_d[bit_q] = rx_bit;
            if (bit_q == last_q) state_d = has_extra_q ? ST_EXTRA : ST_STOP;
            else                 bit_d   = bit_q + 1'b1;
          end else if (tick) begin
            os_d = os_q + 1'b1;
          end
        end
        ST_EXTRA: begin
          if (sample_pt) begin
            os_d    = '0;
            extra_d = rx_bit;
            state_d = ST_STOP;
          end else if (tick) begin
            os_d = os_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (sample_pt) begin
            os_d       = '0;
            frame_done = 1'b1;
            state_d    = ST_IDLE;
          end else if (tick) begin
            os_d = os_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      os_q        <= '0;
      bit_q       <= '0;
      last_q      <= LAST_FULL;
      shift_q     <= '0;
      extra_q     <= 1'b0;
      mp_q        <= 1'b0;
      has_extra_q <= 1'b0;
      odd_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      os_q        <= os_d;
      bit_q       <= bit_d;
      last_q      <= last_d;
      shift_q     <= shift_d;
      extra_q     <= extra_d;
      mp_q        <= mp_d;
      has_extra_q <= has_extra_d;
      odd_q       <= odd_d;
    end
  end

  assign parity_expect          = (^shift_q) ^ odd_q;
  assign frame_data             = shift_q;
  assign frame_flags.addr_bit   = mp_q & extra_q;
  assign frame_flags.frame_err  = ~rx_bit;
  assign frame_flags.parity_err = has_extra_q & ~mp_q & (extra_q ^ parity_expect);

endmodule

// File: rtl/mpu_rx_status.sv
module mpu_rx_status
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  frame_flags_t      frame_flags,
  input  logic              rd_strobe,
  input  logic              int_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr_bit,
  output logic              rx_full,
  output logic              frame_err,
  output logic              parity_err,
  output logic              overrun_err,
  output logic              rx_irq
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              addr_q, addr_d;
  logic              full_q, full_d;
  logic              fe_q, fe_d;
  logic              pe_q, pe_d;
  logic              oe_q, oe_d;
  logic              pend_q, pend_d;

  // next-state logic: errors land with the frame, full follows one cycle later
  always_comb begin
    data_d = data_q;
    addr_d = addr_q;
    full_d = full_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    oe_d   = oe_q;
    pend_d = frame_done;

    if (rd_strobe) begin
      full_d = 1'b0;
      fe_d   = 1'b0;
      pe_d   = 1'b0;
      oe_d   = 1'b0;
    end

    if (frame_done) begin
      fe_d = frame_flags.frame_err;
      pe_d = frame_flags.parity_err;
      oe_d = full_q;
      if (!full_q) begin
        data_d = frame_data;
        addr_d = frame_flags.addr_bit;
      end
    end

    if (pend_q) full_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      addr_q <= 1'b0;
      full_q <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      data_q <= data_d;
      addr_q <= addr_d;
      full_q <= full_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      oe_q   <= oe_d;
      pend_q <= pend_d;
    end
  end

  assign rx_data     = data_q;
  assign rx_addr_bit = addr_q;
  assign rx_full     = full_q;
  assign frame_err   = fe_q;
  assign parity_err  = pe_q;
  assign overrun_err = oe_q;
  assign rx_irq      = full_q & int_en;

endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic              mp_mode,
  input  logic              len_full,
  input  logic              parity_en,
  input  logic              parity_odd,
  input  logic              rx_int_en,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_addr_bit,
  output logic              rx_full,
  output logic              frame_err,
  output logic              parity_err,
  output logic              overrun_err,
  output logic              rx_irq
);

  logic              rst_sync_n;
  logic              rx_bit;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  frame_flags_t      frame_flags;

  // reset asserted asynchronously, released on the clock
  mpu_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  mpu_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) line_sync_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (rx_line),
    .q     (rx_bit)
  );

  mpu_rx_framer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) framer_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (os_tick),
    .rx_bit      (rx_bit),
    .rx_enable   (rx_enable),
    .mp_mode     (mp_mode),
    .len_full    (len_full),
    .parity_en   (parity_en),
    .parity_odd  (parity_odd),
    .frame_done  (frame_done),
    .frame_data  (frame_data),
    .frame_flags (frame_flags)
  );

  mpu_rx_status #(.DATA_W(DATA_W)) status_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_done  (frame_done),
    .frame_data  (frame_data),
    .frame_flags (frame_flags),
    .rd_strobe   (rd_strobe),
    .int_en      (rx_int_en),
    .rx_data     (rx_data),
    .rx_addr_bit (rx_addr_bit),
    .rx_full     (rx_full),
    .frame_err   (frame_err),
    .parity_err  (parity_err),
    .overrun_err (overrun_err),
    .rx_irq      (rx_irq)
  );

endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_enable,
  input logic              rd_strobe,
  input logic              frame_done,
  input logic              rx_full,
  input logic              rx_irq,
  input logic              frame_err,
  input logic              parity_err,
  input logic              overrun_err,
  input logic [DATA_W-1:0] rx_data
);

  // R10
  irq_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_full);

  // R7
  flags_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $stable({frame_err, parity_err, overrun_err}));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !$past(frame_done)) |=> !rx_full);

  // R11
  disabled_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !frame_done);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full) |=> overrun_err);

  // R9
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full) |=> $stable(rx_data));

endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;

  localparam int BIT_CYC = 64;

  typedef struct {
    logic [7:0] d;
    logic       a;
    logic       fe;
    logic       pe;
    logic       oe;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, os_tick, rx_line, rx_enable, mp_mode, len_full;
  logic       parity_en, parity_odd, rx_int_en;
  logic       mon_rd, man_rd;
  logic [7:0] rx_data;
  logic       rx_addr_bit, rx_full, frame_err, parity_err, overrun_err, rx_irq;
  logic [1:0] tick_cnt;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   auto_read = 1'b1;
  exp_t exp_q[$];

  mp_uart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
    .rx_enable(rx_enable), .mp_mode(mp_mode), .len_full(len_full),
    .parity_en(parity_en), .parity_odd(parity_odd), .rx_int_en(rx_int_en),
    .rd_strobe(mon_rd | man_rd), .rx_data(rx_data), .rx_addr_bit(rx_addr_bit),
    .rx_full(rx_full), .frame_err(frame_err), .parity_err(parity_err),
    .overrun_err(overrun_err), .rx_irq(rx_irq)
  );

  // oversampling enable: one pulse every four clocks
  initial begin
    tick_cnt = '0;
    os_tick  = 1'b0;
    forever begin
      @(negedge clk);
      tick_cnt = tick_cnt + 1'b1;
      os_tick  = (tick_cnt == 2'd3);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic push(input logic [7:0] d, input logic a, input logic fe,
                      input logic pe);
    exp_t e;
    e.d = d; e.a = a; e.fe = fe; e.pe = pe; e.oe = 1'b0;
    exp_q.push_back(e);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nbits,
                            input bit has_x, input bit xv, input bit stop_v);
    rx_line = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx_line = d[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    if (has_x) begin
      rx_line = xv;
      repeat (BIT_CYC) @(negedge clk);
    end
    rx_line = stop_v;
    repeat (stop_v ? BIT_CYC : 48) @(negedge clk);
    rx_line = 1'b1;
    repeat (160) @(negedge clk);
  endtask

  // monitor: compare on each rising data-full flag
  initial begin
    logic pf, pfe, ppe, poe;
    exp_t e;
    pf = 1'b0; pfe = 1'b0; ppe = 1'b0; poe = 1'b0;
    mon_rd = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && rx_full && !pf) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R11", "unexpected frame", int'(rx_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(rx_data == e.d, "R2", "rx_data", int'(rx_data), int'(e.d));
          check(rx_addr_bit == e.a, "R6", "rx_addr_bit", int'(rx_addr_bit), int'(e.a));
          // R7: flags already settled the cycle before full rose
          check(pfe == e.fe, "R7", "frame_err before full", int'(pfe), int'(e.fe));
          check(ppe == e.pe, "R7", "parity_err before full", int'(ppe), int'(e.pe));
          check(poe == e.oe, "R7", "overrun_err before full", int'(poe), int'(e.oe));
          check(frame_err == e.fe, "R5", "frame_err", int'(frame_err), int'(e.fe));
          check(parity_err == e.pe, "R4", "parity_err", int'(parity_err), int'(e.pe));
          check(rx_irq == rx_int_en, "R10", "rx_irq", int'(rx_irq), int'(rx_int_en));
        end
        if (auto_read) begin
          mon_rd = 1'b1;
          @(negedge clk);
          mon_rd = 1'b0;
          check(!rx_full, "R8", "rx_full after read", int'(rx_full), 0);
          check(!frame_err && !parity_err && !overrun_err, "R8", "errors after read",
                int'({frame_err, parity_err, overrun_err}), 0);
        end
      end
      pf = rx_full; pfe = frame_err; ppe = parity_err; poe = overrun_err;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; rx_enable = 1'b1; mp_mode = 1'b0;
    len_full = 1'b1; parity_en = 1'b0; parity_odd = 1'b0; rx_int_en = 1'b1;
    man_rd = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R8 reset state
    check(!rx_full, "R8", "reset rx_full", int'(rx_full), 0);
    check(!frame_err && !parity_err && !overrun_err, "R8", "reset errors",
          int'({frame_err, parity_err, overrun_err}), 0);
    check(!rx_irq, "R8", "reset rx_irq", int'(rx_irq), 0);

    // R2 eight-bit normal frames
    push(8'h4D, 0, 0, 0); send_frame(8'h4D, 8, 0, 0, 1);
    push(8'h00, 0, 0, 0); send_frame(8'h00, 8, 0, 0, 1);
    push(8'hFF, 0, 0, 0); send_frame(8'hFF, 8, 0, 0, 1);
    push(8'hA5, 0, 0, 0); send_frame(8'hA5, 8, 0, 0, 1);

    // R3 seven-bit frames; line high after data would otherwise set bit 7
    len_full = 1'b0;
    push(8'h35, 0, 0, 0); send_frame(8'h35, 7, 0, 0, 1);
    push(8'h7F, 0, 0, 0); send_frame(8'h7F, 7, 0, 0, 1);

    // R4 parity: correct even, correct odd, wrong even, seven-bit even
    len_full = 1'b1; parity_en = 1'b1;
    parity_odd = 1'b0;
    push(8'h4D, 0, 0, 0); send_frame(8'h4D, 8, 1, par_bit(8'h4D, 1'b0), 1);
    parity_odd = 1'b1;
    push(8'h4D, 0, 0, 0); send_frame(8'h4D, 8, 1, par_bit(8'h4D, 1'b1), 1);
    parity_odd = 1'b0;
    push(8'h4D, 0, 0, 1); send_frame(8'h4D, 8, 1, ~par_bit(8'h4D, 1'b0), 1);
    len_full = 1'b0;
    push(8'h34, 0, 0, 0); send_frame(8'h34, 7, 1, par_bit(8'h34, 1'b0), 1);
    len_full = 1'b1; parity_en = 1'b0;

    // R5 low stop bit, then a clean frame
    push(8'h5A, 0, 1, 0); send_frame(8'h5A, 8, 0, 0, 0);
    push(8'h3C, 0, 0, 0); send_frame(8'h3C, 8, 0, 0, 1);

    // R1 short low glitch gives no frame
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    check(!rx_full, "R1", "glitch rx_full", int'(rx_full), 0);
    check(exp_q.size() == 0, "R1", "glitch queue", exp_q.size(), 0);
    push(8'h96, 0, 0, 0); send_frame(8'h96, 8, 0, 0, 1);

    // R6 multiprocessor frames: length and parity settings ignored
    mp_mode = 1'b1; len_full = 1'b0; parity_en = 1'b1;
    push(8'h81, 1, 0, 0); send_frame(8'h81, 8, 1, 1, 1);
    push(8'h7E, 0, 0, 0); send_frame(8'h7E, 8, 1, 0, 1);
    push(8'h01, 1, 0, 0); send_frame(8'h01, 8, 1, 1, 1);
    mp_mode = 1'b0; len_full = 1'b1; parity_en = 1'b0;

    // R10 interrupt masked
    rx_int_en = 1'b0;
    push(8'h11, 0, 0, 0); send_frame(8'h11, 8, 0, 0, 1);
    rx_int_en = 1'b1;

    // R11 receiver disabled for a whole frame
    rx_enable = 1'b0;
    send_frame(8'h22, 8, 0, 0, 1);
    check(!rx_full, "R11", "disabled rx_full", int'(rx_full), 0);
    rx_enable = 1'b1;
    repeat (20) @(negedge clk);

    // R11 receiver disabled in the middle of a frame
    fork
      send_frame(8'h00, 8, 0, 0, 1);
      begin
        repeat (BIT_CYC * 3) @(negedge clk);
        rx_enable = 1'b0;
      end
    join
    rx_enable = 1'b1;
    repeat (200) @(negedge clk);
    check(!rx_full, "R11", "aborted rx_full", int'(rx_full), 0);
    check(exp_q.size() == 0, "R11", "aborted queue", exp_q.size(), 0);

    // R9 overrun: second frame while first is unread
    auto_read = 1'b0;
    push(8'hC3, 0, 0, 0); send_frame(8'hC3, 8, 0, 0, 1);
    send_frame(8'h18, 8, 0, 0, 1);
    check(overrun_err, "R9", "overrun_err", int'(overrun_err), 1);
    check(rx_data == 8'hC3, "R9", "kept data", int'(rx_data), 8'hC3);
    check(rx_full, "R9", "rx_full held", int'(rx_full), 1);
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
    check(!rx_full && !overrun_err, "R8", "manual read clears",
          int'({rx_full, overrun_err}), 0);
    auto_read = 1'b1;

    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all frames seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule